// File: doc/BRIEF.md
# Quadrature Step Decoder with Reversal Filter

This block turns the two phase-shifted channels of an incremental encoder into single-cycle step strobes. Both channels, together with a mode input that selects half-resolution counting, are first brought into the clock domain by a flop chain. Each legal change of the two-bit channel state is classified as a step forward or a step backward. From the accepted steps the block produces strobes at full resolution (every edge), half resolution (two per cycle of four edges) and quarter resolution (one per cycle), plus a pair of counter-drive strobes and a direction flag.

A programmable two-bit channel value sets the phase at which the quarter- and half-resolution strobes fire. An optional reversal filter rejects lone direction changes caused by contact bounce: a step against the current direction is held back and only accepted if the next edge continues the same way. A small configuration register, loaded by a strobe, holds the phase value, a force-half-resolution bit and the filter enable.

Top module: `quad_step_decoder`

## Requirements
- R1: With the default two synchronizer stages, a legal channel change driven before clock edge k produces its strobe in the cycle that follows edge k+2, and each strobe lasts one cycle.
- R2: Channel states {A,B} are ranked 00=0, 01=1, 11=2, 10=3; a change to the next rank (mod 4) is a forward step and raises x4_up, a change to the previous rank is a backward step and raises x4_dn, one strobe per accepted edge.
- R3: A change of both channels in one sample is a jump: it raises no strobe, leaves dir unchanged, becomes the new reference state and cancels any held reversal.
- R4: With phase rank p (the rank of the configured {A,B} value, bit 1 = A), x1_up fires on an accepted forward step into rank p and x1_dn on an accepted backward step out of rank p.
- R5: x2_up fires on an accepted forward step into a rank with the same low bit as p, x2_dn on an accepted backward step out of such a rank.
- R6: cnt_up/cnt_dn follow the half-resolution strobes when the synchronized x2_sel_in is 1 or the force bit is set, and the quarter-resolution strobes otherwise; the force bit overrides a low x2_sel_in.
- R7: dir is 1 after reset and after an accepted forward step, 0 after an accepted backward step.
- R8: With the filter on, a step against dir raises no strobe and leaves dir unchanged; a following step in that same new direction is accepted with one strobe and flips dir; a following step back in the old direction raises no strobe and cancels the held reversal.
- R9: With the filter off, every legal step is accepted at once in either direction.
- R10: The configuration register resets to phase 00, force off, filter on; it loads only on a clock edge with cfg_load high and otherwise ignores the cfg inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chan_a | input | 1 | Encoder channel A, asynchronous |
| chan_b | input | 1 | Encoder channel B, asynchronous |
| x2_sel_in | input | 1 | Select half resolution for the counter strobes, asynchronous |
| cfg_load | input | 1 | Load the cfg fields into the configuration register |
| cfg_x1_gray | input | 2 | Channel value {A,B} that marks the strobe phase |
| cfg_force_x2 | input | 1 | Force half resolution for the counter strobes |
| cfg_debounce_en | input | 1 | Enable the reversal filter |
| x4_up | output | 1 | Full-resolution forward strobe |
| x4_dn | output | 1 | Full-resolution backward strobe |
| x2_up | output | 1 | Half-resolution forward strobe |
| x2_dn | output | 1 | Half-resolution backward strobe |
| x1_up | output | 1 | Quarter-resolution forward strobe |
| x1_dn | output | 1 | Quarter-resolution backward strobe |
| cnt_up | output | 1 | Counter-drive forward strobe |
| cnt_dn | output | 1 | Counter-drive backward strobe |
| dir | output | 1 | Accepted direction, 1 = forward |

## Verification
The confirmation of a held reversal and a crossing of the phase point can land on the same edge, so the filter's accept decision and the phase selection must both act in one cycle. The bench provokes this by loading the phase so that the confirming backward step leaves rank p, then expects x4_dn, x1_dn, cnt_dn and the dir flip together in that single cycle. Around this, every phase value is swept against all four combinations of the mode input and the force bit over full forward and backward turns, with each strobe's expected count worked out from the rank arithmetic.

// File: rtl/qd_pkg.sv
// Shared types and helpers for the quadrature step decoder.
package qd_pkg;

    // Rank of a channel state in the forward sequence (0..3).
    typedef logic [1:0] qrank_t;

    // Configuration register contents.
    typedef struct packed {
        logic [1:0] x1_gray;
        logic       force_x2;
        logic       debounce_en;
    } qd_cfg_t;

    localparam qd_cfg_t CFG_RESET = '{x1_gray: 2'b00, force_x2: 1'b0, debounce_en: 1'b1};

    // Map {A,B} to its rank: 00->0, 01->1, 11->2, 10->3.
    function automatic qrank_t gray_to_rank(input logic [1:0] ab);
        return {ab[1], ab[1] ^ ab[0]};
    endfunction

endpackage

// File: rtl/qd_sync.sv
// Flop-chain synchronizer for a bundle of asynchronous inputs.
// Assumes each bit is individually glitch tolerant; bits are not
// guaranteed to cross together, which the decoder treats as separate edges.
module qd_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    // Shift the inputs through the chain; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/qd_transition.sv
// Compares the synchronized channel state against a reference state and
// classifies any change as a forward step, backward step or jump.
// Assumes the input is already synchronized. The reference follows the
// input every cycle; decoding starts only once the synchronizer has filled.
module qd_transition
    import qd_pkg::*;
#(
    parameter int SETTLE = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ab,
    output logic       step_fwd,
    output logic       step_bwd,
    output logic       jump,
    output qrank_t     from_rank,
    output qrank_t     to_rank
);
    localparam int ARM_LIMIT = SETTLE + 1;
    localparam int AW        = $clog2(ARM_LIMIT + 1);

    logic [1:0]    ref_q;
    logic [AW-1:0] arm_q;
    logic          armed;
    logic          moved;
    qrank_t        delta;

    assign armed = (arm_q == AW'(ARM_LIMIT));

    // Count the settling cycles after reset before decoding is trusted.
    always_ff @(posedge clk) begin
        if (!rst_n)      arm_q <= '0;
        else if (!armed) arm_q <= arm_q + 1'b1;
    end

    // Track the last observed channel state as the reference.
    always_ff @(posedge clk) begin
        if (!rst_n) ref_q <= 2'b00;
        else        ref_q <= ab;
    end

    // Classify the change by the rank distance between the two states.
    always_comb begin
        from_rank = gray_to_rank(ref_q);
        to_rank   = gray_to_rank(ab);
        delta     = to_rank - from_rank;
        moved     = armed && (ab != ref_q);
        step_fwd  = moved && (delta == 2'd1);
        step_bwd  = moved && (delta == 2'd3);
        jump      = moved && (delta == 2'd2);
    end

endmodule

// File: rtl/qd_reversal_filter.sv
// Accepts or holds back steps and keeps the accepted direction.
// With the filter enabled, a step against the current direction is held;
// it is accepted only if the next step goes the same way, and cancelled if
// the next step returns or a jump occurs. Disabled, every step is accepted.
module qd_reversal_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic filter_en,
    input  logic step_fwd,
    input  logic step_bwd,
    input  logic jump,
    output logic acc_up,
    output logic acc_dn,
    output logic dir_q
);
    logic pend_q;
    logic pend_d;
    logic dir_d;

    // Decide acceptance and the next direction / held-reversal state.
    always_comb begin
        acc_up = 1'b0;
        acc_dn = 1'b0;
        dir_d  = dir_q;
        pend_d = pend_q;
        if (jump) begin
            pend_d = 1'b0;
        end else if (step_fwd || step_bwd) begin
            if (!filter_en) begin
                acc_up = step_fwd;
                acc_dn = step_bwd;
                dir_d  = step_fwd;
                pend_d = 1'b0;
            end else if (step_fwd == dir_q) begin
                if (pend_q) begin
                    pend_d = 1'b0;
                end else begin
                    acc_up = step_fwd;
                    acc_dn = step_bwd;
                end
            end else if (pend_q) begin
                acc_up = step_fwd;
                acc_dn = step_bwd;
                dir_d  = step_fwd;
                pend_d = 1'b0;
            end else begin
                pend_d = 1'b1;
            end
        end else if (!filter_en) begin
            pend_d = 1'b0;
        end
    end

    // Hold direction (forward after reset) and the held-reversal flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= 1'b1;
            pend_q <= 1'b0;
        end else begin
            dir_q  <= dir_d;
            pend_q <= pend_d;
        end
    end

endmodule

// File: rtl/qd_phase_select.sv
// Derives quarter- and half-resolution strobes from accepted steps and the
// configured phase, and picks the counter-drive pair. Purely combinational;
// assumes from/to ranks belong to the step being accepted.
module qd_phase_select
    import qd_pkg::*;
(
    input  logic       acc_up,
    input  logic       acc_dn,
    input  qrank_t     from_rank,
    input  qrank_t     to_rank,
    input  logic [1:0] phase_gray,
    input  logic       use_x2,
    output logic       x1_up,
    output logic       x1_dn,
    output logic       x2_up,
    output logic       x2_dn,
    output logic       cnt_up,
    output logic       cnt_dn
);
    qrank_t p;

    // Fire on crossings of the boundary into rank p (and p+2 for half).
    always_comb begin
        p      = gray_to_rank(phase_gray);
        x1_up  = acc_up && (to_rank == p);
        x1_dn  = acc_dn && (from_rank == p);
        x2_up  = acc_up && (to_rank[0] == p[0]);
        x2_dn  = acc_dn && (from_rank[0] == p[0]);
        cnt_up = use_x2 ? x2_up : x1_up;
        cnt_dn = use_x2 ? x2_dn : x1_dn;
    end

endmodule

// File: rtl/quad_step_decoder.sv
// Quadrature step decoder: synchronizes the channels and the half-resolution
// select, classifies edges, filters lone reversals and registers all strobes.
// Assumes channel edges are at least one clock apart per channel after
// synchronization; faster changes appear as jumps.
module quad_step_decoder
    import qd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chan_a,
    input  logic       chan_b,
    input  logic       x2_sel_in,
    input  logic       cfg_load,
    input  logic [1:0] cfg_x1_gray,
    input  logic       cfg_force_x2,
    input  logic       cfg_debounce_en,
    output logic       x4_up,
    output logic       x4_dn,
    output logic       x2_up,
    output logic       x2_dn,
    output logic       x1_up,
    output logic       x1_dn,
    output logic       cnt_up,
    output logic       cnt_dn,
    output logic       dir
);
    qd_cfg_t    cfg_q;
    logic [2:0] sync_out;
    logic       step_fwd, step_bwd, jump;
    qrank_t     from_rank, to_rank;
    logic       acc_up, acc_dn;
    logic       p_x1_up, p_x1_dn, p_x2_up, p_x2_dn, p_cnt_up, p_cnt_dn;
    logic       use_x2;

    // Configuration register, loaded by strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        cfg_q <= CFG_RESET;
        else if (cfg_load) cfg_q <= '{x1_gray: cfg_x1_gray, force_x2: cfg_force_x2,
                                      debounce_en: cfg_debounce_en};
    end

    qd_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .din ({chan_a, chan_b, x2_sel_in}),
        .dout (sync_out)
    );

    qd_transition #(.SETTLE(SYNC_STAGES)) u_trans (
        .clk (clk),
        .rst_n (rst_n),
        .ab (sync_out[2:1]),
        .step_fwd (step_fwd),
        .step_bwd (step_bwd),
        .jump (jump),
        .from_rank (from_rank),
        .to_rank (to_rank)
    );

    qd_reversal_filter u_filter (
        .clk (clk),
        .rst_n (rst_n),
        .filter_en (cfg_q.debounce_en),
        .step_fwd (step_fwd),
        .step_bwd (step_bwd),
        .jump (jump),
        .acc_up (acc_up),
        .acc_dn (acc_dn),
        .dir_q (dir)
    );

    assign use_x2 = sync_out[0] | cfg_q.force_x2;

    qd_phase_select u_phase (
        .acc_up (acc_up),
        .acc_dn (acc_dn),
        .from_rank (from_rank),
        .to_rank (to_rank),
        .phase_gray (cfg_q.x1_gray),
        .use_x2 (use_x2),
        .x1_up (p_x1_up),
        .x1_dn (p_x1_dn),
        .x2_up (p_x2_up),
        .x2_dn (p_x2_dn),
        .cnt_up (p_cnt_up),
        .cnt_dn (p_cnt_dn)
    );

    // Register every strobe so all outputs change on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {x4_up, x4_dn, x2_up, x2_dn, x1_up, x1_dn, cnt_up, cnt_dn} <= '0;
        end else begin
            {x4_up, x4_dn, x2_up, x2_dn, x1_up, x1_dn, cnt_up, cnt_dn} <=
                {acc_up, acc_dn, p_x2_up, p_x2_dn, p_x1_up, p_x1_dn, p_cnt_up, p_cnt_dn};
        end
    end

    // Only one direction strobe at a time at full resolution.
    assert_single_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({x4_up, x4_dn}));

    // A jump seen by the classifier never yields a strobe.
    assert_jump_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        jump |=> !(x4_up || x4_dn));

    // Quarter-resolution strobes are a subset of full-resolution ones.
    assert_x1_in_x4_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (x1_up |-> x4_up) and (x1_dn |-> x4_dn));

    // Quarter-resolution strobes are a subset of half-resolution ones.
    assert_x1_in_x2_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (x1_up |-> x2_up) and (x1_dn |-> x2_dn));

    // Counter strobes come from one of the two resolutions.
    assert_cnt_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_up |-> (x1_up || x2_up)) and (cnt_dn |-> (x1_dn || x2_dn)));

    // Direction agrees with the strobe issued alongside it.
    assert_dir_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (x4_up |-> dir) and (x4_dn |-> !dir));

    // Direction moves only together with an accepted strobe.
    assert_dir_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(x4_up || x4_dn) |-> $stable(dir));

endmodule

// File: tb/quad_step_decoder_tb.sv
module quad_step_decoder_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chan_a = 1'b0, chan_b = 1'b0, x2_sel_in = 1'b0;
    logic cfg_load = 1'b0;
    logic [1:0] cfg_x1_gray = 2'b00;
    logic cfg_force_x2 = 1'b0, cfg_debounce_en = 1'b1;
    logic x4_up, x4_dn, x2_up, x2_dn, x1_up, x1_dn, cnt_up, cnt_dn, dir;

    int total = 0;
    int bad = 0;
    logic [1:0] pos = 2'd0;
    int n4u, n4d, n2u, n2d, n1u, n1d, ncu, ncd;

    always #5 clk = ~clk;

    quad_step_decoder u_dut (
        .clk (clk), .rst_n (rst_n), .chan_a (chan_a), .chan_b (chan_b),
        .x2_sel_in (x2_sel_in), .cfg_load (cfg_load), .cfg_x1_gray (cfg_x1_gray),
        .cfg_force_x2 (cfg_force_x2), .cfg_debounce_en (cfg_debounce_en),
        .x4_up (x4_up), .x4_dn (x4_dn), .x2_up (x2_up), .x2_dn (x2_dn),
        .x1_up (x1_up), .x1_dn (x1_dn), .cnt_up (cnt_up), .cnt_dn (cnt_dn), .dir (dir)
    );

    function automatic logic [1:0] rank_to_ab(input logic [1:0] r);
        return {r[1], r[1] ^ r[0]};
    endfunction

    function automatic logic [1:0] ab_to_rank(input logic [1:0] g);
        return {g[1], g[1] ^ g[0]};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] g, input logic frc, input logic deb);
        @(negedge clk);
        cfg_x1_gray = g; cfg_force_x2 = frc; cfg_debounce_en = deb; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    // Move the channels by delta ranks and count strobes over five cycles.
    task automatic step(input int delta);
        logic [1:0] d;
        d = delta[1:0];
        @(negedge clk);
        pos = pos + d;
        {chan_a, chan_b} = rank_to_ab(pos);
        n4u = 0; n4d = 0; n2u = 0; n2d = 0; n1u = 0; n1d = 0; ncu = 0; ncd = 0;
        repeat (5) begin
            @(negedge clk);
            n4u += int'(x4_up); n4d += int'(x4_dn); n2u += int'(x2_up); n2d += int'(x2_dn);
            n1u += int'(x1_up); n1d += int'(x1_dn); ncu += int'(cnt_up); ncd += int'(cnt_dn);
        end
    endtask

    task automatic summary;
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        logic [1:0] ip;
        logic [1:0] frm;
        int sum1;
        int sumc;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);

        // Reset state (R7, R10)
        check("R7 reset dir", int'(dir), 1);
        check("R10 reset strobes", int'({x4_up, x4_dn, x2_up, x2_dn, x1_up, x1_dn, cnt_up, cnt_dn}), 0);

        // Latency and width (R1): forward 0->1 under reset config.
        @(negedge clk);
        pos = 2'd1;
        {chan_a, chan_b} = rank_to_ab(pos);
        @(negedge clk); check("R1 no strobe cycle 1", int'(x4_up), 0);
        @(negedge clk); check("R1 no strobe cycle 2", int'(x4_up), 0);
        @(negedge clk); check("R1 strobe cycle 3", int'(x4_up), 1);
        check("R10 reset phase 00 no x1 into rank 1", int'(x1_up), 0);
        @(negedge clk); check("R1 one-cycle width", int'(x4_up), 0);

        // Reset config has the filter on (R10, R8): reversal held, return cancels.
        step(-1);
        check("R10 filter on after reset", n4u + n4d, 0);
        check("R8 held reversal dir", int'(dir), 1);
        step(1);
        check("R8 return cancels hold", n4u + n4d, 0);
        sum1 = 0; sumc = 0;
        for (int i = 0; i < 4; i++) begin
            step(1);
            check("R2 forward x4", n4u, 1);
            sum1 += n1u; sumc += ncu;
        end
        check("R4 one x1 per turn", sum1, 1);
        check("R6 cnt follows x1 by default", sumc, 1);

        // Sweep of phase and counter-source selection, filter off (R2 R4 R5 R6 R7 R9).
        for (int g = 0; g < 4; g++) begin
            for (int m = 0; m < 4; m++) begin
                cfg_write(g[1:0], m[1], 1'b0);
                x2_sel_in = m[0];
                repeat (4) @(negedge clk);
                ip = ab_to_rank(g[1:0]);
                for (int s = 0; s < 8; s++) begin
                    step(1);
                    check("R2 fwd x4_up", n4u, 1);
                    check("R2 fwd x4_dn", n4d, 0);
                    check("R4 fwd x1_up", n1u, int'(pos == ip));
                    check("R5 fwd x2_up", n2u, int'(pos[0] == ip[0]));
                    check("R6 fwd cnt_up", ncu, (m != 0) ? int'(pos[0] == ip[0]) : int'(pos == ip));
                    check("R7 fwd dir", int'(dir), 1);
                end
                for (int s = 0; s < 8; s++) begin
                    frm = pos;
                    step(-1);
                    check("R9 bwd accepted at once", n4d, 1);
                    check("R2 bwd x4_up", n4u, 0);
                    check("R4 bwd x1_dn", n1d, int'(frm == ip));
                    check("R5 bwd x2_dn", n2d, int'(frm[0] == ip[0]));
                    check("R6 bwd cnt_dn", ncd, (m != 0) ? int'(frm[0] == ip[0]) : int'(frm == ip));
                    check("R7 bwd dir", int'(dir), 0);
                end
            end
        end
        x2_sel_in = 1'b0;
        repeat (4) @(negedge clk);

        // Jump with filter off (R3): silent, then reference moved.
        cfg_write(2'b00, 1'b0, 1'b0);
        step(2);
        check("R3 jump silent", n4u + n4d, 0);
        check("R3 jump keeps dir", int'(dir), 0);
        step(1);
        check("R3 reference updated", n4u, 1);

        // Config ignored without load (R10): other values presented, load low.
        cfg_x1_gray = 2'b11; cfg_force_x2 = 1'b1; cfg_debounce_en = 1'b1;
        repeat (2) @(negedge clk);
        sumc = 0;
        for (int i = 0; i < 4; i++) begin
            step(1);
            check("R10 phase kept x1", n1u, int'(pos == 2'd0));
            sumc += ncu;
        end
        check("R10 force not loaded", sumc, 1);
        step(-1);
        check("R10 filter-off kept", n4d, 1);

        // Reversal filter sequence (R8, R3).
        cfg_write(2'b00, 1'b0, 1'b0);
        step(1);
        cfg_write(2'b00, 1'b0, 1'b1);
        step(1);  check("R8 same dir accepted", n4u, 1);
        step(-1); check("R8 reversal held", n4u + n4d, 0);
        check("R8 reversal dir held", int'(dir), 1);
        step(-1); check("R8 confirm strobe", n4d, 1);
        check("R8 confirm dir", int'(dir), 0);
        step(1);  check("R8 reversal held 2", n4u + n4d, 0);
        step(-1); check("R8 return no strobe", n4u + n4d, 0);
        step(-1); check("R8 hold cancelled", n4d, 1);
        step(1);  check("R8 reversal held 3", n4u + n4d, 0);
        step(2);  check("R3 jump silent filtered", n4u + n4d, 0);
        step(1);  check("R3 hold cleared by jump", n4u + n4d, 0);
        check("R3 dir after jump", int'(dir), 0);
        step(1);  check("R8 confirm after jump", n4u, 1);
        check("R8 dir forward", int'(dir), 1);

        // Same cycle: confirmation coincides with leaving phase rank (R8 R4 R6).
        ip = pos - 2'd1;
        cfg_write(rank_to_ab(ip), 1'b0, 1'b1);
        step(-1); check("R8 held before phase", n4u + n4d + n1d, 0);
        step(-1);
        check("R8 confirm with phase x4_dn", n4d, 1);
        check("R4 confirm with phase x1_dn", n1d, 1);
        check("R6 confirm with phase cnt_dn", ncd, 1);
        check("R7 confirm with phase dir", int'(dir), 0);

        summary();
        $finish;
    end

endmodule